// File: doc/BRIEF.md
# Cascadable Decade Counter Stage

This block is one decimal digit of a synchronous counter. It holds a 4-bit value that steps through 0 to 9 and wraps back to 0. On a clock edge it can instead take a 4-bit preset value, or it can keep its current value. Two separate count-enable inputs decide whether it steps. A carry output marks the terminal digit 9. That carry can drive the carry-gating enable of the next stage. Several stages sharing one clock then form a multi-digit decimal counter, and no stage needs a clock of its own.

The preset may be any 4-bit value, including the six codes above 9. The stage leaves those codes along a fixed path and is back in the decimal range after at most two counting edges. A build-time parameter picks the reset style. With asynchronous reset, the count clears as soon as the reset is low. With synchronous reset, it clears at the next rising clock edge.

Top module: `decade_counter_stage`

## Requirements
- R1: With SYNC_RESET = 0, a low reset_n forces count to 0000 at once, without waiting for a clock edge, and holds it there while reset_n stays low.
- R2: With SYNC_RESET = 1, a low reset_n changes nothing before the next rising edge. At that edge count becomes 0000.
- R3: When reset_n is high and load_n is low at a rising edge, count takes the value of preset, with preset[0] as the least significant bit. This happens whatever enable_p and enable_t are.
- R4: When reset_n, load_n, enable_p and enable_t are all high at a rising edge, count advances by one within 0 to 9, and 9 (1001) becomes 0 (0000).
- R5: When reset_n and load_n are high and enable_p or enable_t is low at a rising edge, count keeps its value.
- R6: carry is high exactly while count is 1001 and enable_t is high. It follows enable_t without waiting for a clock edge and does not depend on enable_p or load_n.
- R7: When counting is enabled, the invalid codes step as follows: 1010 to 1011, 1011 to 0100, 1100 to 1101, 1101 to 0100, 1110 to 1111, 1111 to 0000. carry stays low in all six of these states.
- R8: Reset takes precedence over load. A low reset_n together with a low load_n gives count 0000.
- R9: With two stages chained, the first stage's carry driving the second stage's enable_t, the pair counts 00 to 99 and then wraps to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| reset_n | input | 1 | Active-low clear; asynchronous or synchronous according to SYNC_RESET |
| load_n | input | 1 | Active-low parallel load of preset |
| enable_p | input | 1 | Count enable that has no effect on carry |
| enable_t | input | 1 | Count enable that also gates carry |
| preset | input | 4 | Value loaded into count; bit 0 is least significant |
| count | output | 4 | Current digit |
| carry | output | 1 | High while count is 1001 and enable_t is high |

## Verification
The six codes above 9 cannot be reached by counting. The only way into them is a parallel load, and each one is left after at most two counting edges. For each code, the bench therefore loads it, checks that carry stays low with enable_t high, and then lets the stage take two counting steps, checking every intermediate value. Random load, enable and reset traffic on a synchronous-reset instance also drops into these codes, and random enable gaps interrupt their recovery paths. A bench model follows all of this traffic.

// File: rtl/decade_pkg.sv
package decade_pkg;

   localparam int unsigned DIGIT_W = 4;

   typedef logic [DIGIT_W-1:0] digit_t;

   localparam digit_t DIGIT_TOP = digit_t'(9);

   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_STEP  = 2'd1,
      OP_LOAD  = 2'd2,
      OP_CLEAR = 2'd3
   } digit_op_e;

   // successor of a digit, including the fixed exit path of the six non-decimal codes
   function automatic digit_t digit_succ(input digit_t d);
      digit_t r;
      case (d)
         digit_t'(9):  r = digit_t'(0);
         digit_t'(10): r = digit_t'(11);
         digit_t'(11): r = digit_t'(4);
         digit_t'(12): r = digit_t'(13);
         digit_t'(13): r = digit_t'(4);
         digit_t'(14): r = digit_t'(15);
         digit_t'(15): r = digit_t'(0);
         default:      r = d + digit_t'(1);
      endcase
      return r;
   endfunction

endpackage

// File: rtl/dcnt_ctrl.sv
module dcnt_ctrl
   import decade_pkg::*;
(
   input  logic      rst_n,
   input  logic      load_n,
   input  logic      en_p,
   input  logic      en_t,
   output digit_op_e op
);

   always_comb begin
      if (!rst_n)              op = OP_CLEAR;
      else if (!load_n)        op = OP_LOAD;
      else if (en_p && en_t)   op = OP_STEP;
      else                     op = OP_HOLD;
   end

endmodule

// File: rtl/dcnt_next.sv
module dcnt_next
   import decade_pkg::*;
(
   input  digit_op_e op,
   input  digit_t    cur,
   input  digit_t    preset,
   output digit_t    nxt
);

   always_comb begin
      unique case (op)
         OP_CLEAR: nxt = '0;
         OP_LOAD:  nxt = preset;
         OP_STEP:  nxt = digit_succ(cur);
         default:  nxt = cur;
      endcase
   end

endmodule

// File: rtl/dcnt_reg.sv
module dcnt_reg
   import decade_pkg::*;
#(
   parameter bit SYNC_RESET = 1'b0
) (
   input  logic   clk,
   input  logic   rst_n,
   input  digit_t d,
   output digit_t q
);

   generate
      if (SYNC_RESET) begin : g_sync_clr
         // clearing arrives through d from the control decode
         always_ff @(posedge clk) begin
            q <= d;
         end
      end else begin : g_async_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end
   endgenerate

endmodule

// File: rtl/dcnt_carry.sv
module dcnt_carry
   import decade_pkg::*;
(
   input  digit_t cur,
   input  logic   en_t,
   output logic   carry
);

   assign carry = en_t && (cur == DIGIT_TOP);

endmodule

// File: rtl/decade_counter_stage.sv
module decade_counter_stage
   import decade_pkg::*;
#(
   parameter bit          SYNC_RESET = 1'b0,
   parameter int unsigned CNT_W      = 4
) (
   input  logic             clk,
   input  logic             reset_n,
   input  logic             load_n,
   input  logic             enable_p,
   input  logic             enable_t,
   input  logic [CNT_W-1:0] preset,
   output logic [CNT_W-1:0] count,
   output logic             carry
);

   generate
      if (CNT_W != DIGIT_W) begin : g_bad_width
         $error("decade_counter_stage: CNT_W must equal 4");
      end
   endgenerate

   digit_op_e op;
   digit_t    cur_q;
   digit_t    nxt_d;

   dcnt_ctrl u_ctrl (
      .rst_n (reset_n),
      .load_n(load_n),
      .en_p  (enable_p),
      .en_t  (enable_t),
      .op    (op)
   );

   dcnt_next u_next (
      .op    (op),
      .cur   (cur_q),
      .preset(digit_t'(preset)),
      .nxt   (nxt_d)
   );

   dcnt_reg #(.SYNC_RESET(SYNC_RESET)) u_reg (
      .clk  (clk),
      .rst_n(reset_n),
      .d    (nxt_d),
      .q    (cur_q)
   );

   dcnt_carry u_carry (
      .cur  (cur_q),
      .en_t (enable_t),
      .carry(carry)
   );

   assign count = CNT_W'(cur_q);

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!reset_n)
      !load_n |=> count == $past(preset)) else $error("load"); // R3

   AST_STEP_UP: assert property (@(posedge clk) disable iff (!reset_n)
      (load_n && enable_p && enable_t && count < CNT_W'(9)) |=> count == $past(count) + CNT_W'(1))
      else $error("step"); // R4

   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!reset_n)
      (load_n && enable_p && enable_t && count == CNT_W'(9)) |=> count == '0)
      else $error("wrap"); // R4

   AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!reset_n)
      (load_n && !(enable_p && enable_t)) |=> $stable(count)) else $error("hold"); // R5

   AST_CARRY_GATED: assert property (@(posedge clk) disable iff (!reset_n)
      carry |-> enable_t) else $error("carry gate"); // R6

   AST_CARRY_INVALID: assert property (@(posedge clk) disable iff (!reset_n)
      (count > CNT_W'(9)) |-> !carry) else $error("carry invalid"); // R7

   AST_INVALID_EXIT: assert property (@(posedge clk) disable iff (!reset_n)
      (load_n && enable_p && enable_t && count > CNT_W'(9))
      |=> (count == CNT_W'(11) || count == CNT_W'(13) || count == CNT_W'(15)
           || count == CNT_W'(4) || count == '0)) else $error("invalid exit"); // R7

endmodule

// File: tb/decade_counter_stage_tb_top.sv
module decade_counter_stage_tb_top;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_a, ld_a, cen;
   logic [3:0] pre_lo, pre_hi;
   logic [3:0] q_lo, q_hi;
   logic       c_lo, c_hi;

   logic       rst_s, ld_s, ep_s, et_s;
   logic [3:0] pre_s, q_s;
   logic       c_s;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #(CLK_P/2) clk = ~clk;

   decade_counter_stage #(.SYNC_RESET(1'b0)) dut_i (
      .clk(clk), .reset_n(rst_a), .load_n(ld_a), .enable_p(1'b1), .enable_t(cen),
      .preset(pre_lo), .count(q_lo), .carry(c_lo));

   decade_counter_stage #(.SYNC_RESET(1'b0)) dut_hi (
      .clk(clk), .reset_n(rst_a), .load_n(ld_a), .enable_p(1'b1), .enable_t(c_lo),
      .preset(pre_hi), .count(q_hi), .carry(c_hi));

   decade_counter_stage #(.SYNC_RESET(1'b1)) dut_s (
      .clk(clk), .reset_n(rst_s), .load_n(ld_s), .enable_p(ep_s), .enable_t(et_s),
      .preset(pre_s), .count(q_s), .carry(c_s));

   function automatic logic [3:0] succ_model(input logic [3:0] d);
      if (d < 4'd9)  return d + 4'd1;
      if (d == 4'd9) return 4'd0;
      if (d == 4'd10) return 4'd11;
      if (d == 4'd12) return 4'd13;
      if (d == 4'd14) return 4'd15;
      if (d == 4'd15) return 4'd0;
      return 4'd4;
   endfunction

   function automatic logic [3:0] edge_model(input logic r, input logic l, input logic p,
                                             input logic t, input logic [3:0] pr,
                                             input logic [3:0] cur);
      if (!r) return 4'd0;
      if (!l) return pr;
      if (p && t) return succ_model(cur);
      return cur;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk); #1;
   endtask

   task automatic sync_step(input logic r, input logic l, input logic p, input logic t,
                            input logic [3:0] pr, input string req);
      logic [3:0] exp_q;
      @(negedge clk);
      rst_s = r; ld_s = l; ep_s = p; et_s = t; pre_s = pr;
      #1;
      check("R6", int'(c_s), int'(t && q_s == 4'd9));
      if (q_s > 4'd9) check("R7", int'(c_s), 0);
      exp_q = edge_model(r, l, p, t, pr, q_s);
      tick();
      check(req, int'(q_s), int'(exp_q));
   endtask

   initial begin
      #(CLK_P * 150000);
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
      end
      $finish;
   end

   initial begin
      int v;
      process_init();
      tick(); tick();
      check("R1", int'(q_lo), 0);
      check("R2", int'(q_s), 0);

      // cascade: 00..99 and wrap
      @(negedge clk); rst_a = 1; rst_s = 1; cen = 1;
      for (int i = 1; i <= 100; i++) begin
         tick();
         v = int'(q_hi) * 10 + int'(q_lo);
         check("R9", v, i % 100);
         if (i == 99) begin
            #1 check("R9", int'(c_hi), 1);
         end
      end
      // load mid-count
      @(negedge clk); ld_a = 0; pre_lo = 4'd7; pre_hi = 4'd4;
      tick(); check("R3", int'(q_hi) * 10 + int'(q_lo), 47);
      @(negedge clk); ld_a = 1;
      for (int i = 0; i < 5; i++) tick();
      check("R9", int'(q_hi) * 10 + int'(q_lo), 52);
      // hold via enable_t low on low stage
      @(negedge clk); cen = 0; #1;
      check("R6", int'(c_lo), 0);
      tick(); tick();
      check("R5", int'(q_hi) * 10 + int'(q_lo), 52);
      // async reset between edges
      @(negedge clk); rst_a = 0; #1;
      check("R1", int'(q_hi) * 10 + int'(q_lo), 0);
      tick();
      check("R1", int'(q_lo), 0);
      @(negedge clk); rst_a = 1;

      // sync reset waits for the edge
      sync_step(1, 0, 1, 1, 4'd6, "R3");
      @(negedge clk); rst_s = 0; #1;
      check("R2", int'(q_s), 6);
      tick(); check("R2", int'(q_s), 0);
      // reset over load
      sync_step(0, 0, 1, 1, 4'd8, "R8");
      // load ignores enables
      sync_step(1, 0, 0, 0, 4'd9, "R3");
      sync_step(1, 1, 0, 1, 4'd0, "R5");
      sync_step(1, 1, 1, 0, 4'd0, "R5");
      sync_step(1, 1, 1, 1, 4'd0, "R4");
      check("R4", int'(q_s), 0);

      // each invalid code: load then two counting edges
      for (int code = 10; code < 16; code++) begin
         sync_step(1, 0, 0, 1, 4'(code), "R3");
         sync_step(1, 1, 1, 1, 4'd0, "R7");
         sync_step(1, 1, 1, 1, 4'd0, "R7");
         check("R7", int'(q_s <= 4'd9), 1);
      end

      // constrained random traffic
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < 3000; i++) begin
         logic r, l, p, t;
         r = ($urandom % 40) != 0;
         l = ($urandom % 8) != 0;
         p = ($urandom % 5) != 0;
         t = ($urandom % 5) != 0;
         sync_step(r, l, p, t, 4'($urandom), l ? "R4" : "R3");
      end

      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
      end
      $finish;
   end

   task automatic process_init;
      rst_a = 0; ld_a = 1; cen = 0; pre_lo = 0; pre_hi = 0;
      rst_s = 0; ld_s = 1; ep_s = 0; et_s = 0; pre_s = 0;
   endtask

endmodule